// File: doc/BRIEF.md
# RTC Alarm Match with Pulsed Interrupt

This block watches the running calendar-clock fields (seconds, minutes, hours, date, month, day of week) and compares them against six alarm registers. Each alarm register carries its own enable flag, so software can build anything from a once-a-minute alarm to a single date and time. When every enabled field equals the matching time field at a one-second tick, the block records an alarm event.

An event always sets a sticky status flag. The active-low interrupt line then behaves in one of two ways, chosen by a mode input. In pulse mode it drops for a fixed number of clock cycles on every matching tick, with no need for the status flag to be serviced. In level mode it stays low until software clears the status flag. The time fields come from a separate timekeeping counter, which updates them before it raises the tick.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, irq_n is 1 and alarm_flag is 0.
- R2: Bit 7 of each alarm register enables its field, and bits 6:0 hold the BCD compare value. An alarm event occurs on a cycle with sec_tick=1 when every enabled field's compare value equals the whole 8-bit time field (for example, 0xB0 matches seconds equal to 0x30).
- R3: A field whose bit 7 is 0 (for example, the value 0x00) takes no part in the match. Its compare value and its time field have no effect.
- R4: If no alarm register has bit 7 set, no event ever occurs.
- R5: The match is evaluated only on cycles with sec_tick=1. A match without a tick leaves irq_n and alarm_flag unchanged, and each tick yields at most one event.
- R6: With irq_mode=1, an event drives irq_n low for exactly PULSE_CYCLES clock cycles. The pulse starts in the cycle after the tick.
- R7: In pulse mode every matching tick gives a new pulse, even when alarm_flag is never cleared. With only seconds enabled at 0xB0, the block gives one pulse each time the seconds reach 0x30, which is once every 60 ticks.
- R8: alarm_flag goes to 1 in the cycle after each event and holds until status_clr=1 clears it one cycle later. An event in the same cycle as status_clr keeps the flag at 1.
- R9: With irq_mode=0, irq_n is the inverse of alarm_flag. It goes low in the cycle after an event and stays low until the flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, high once the time fields have updated |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current date, BCD |
| now_month | input | 8 | Current month, BCD |
| now_dow | input | 8 | Current day of week, BCD |
| alm_sec | input | 8 | Seconds alarm: bit 7 enable, bits 6:0 value |
| alm_min | input | 8 | Minutes alarm |
| alm_hour | input | 8 | Hours alarm |
| alm_date | input | 8 | Date alarm |
| alm_month | input | 8 | Month alarm |
| alm_dow | input | 8 | Day-of-week alarm |
| irq_mode | input | 1 | 1 = pulse interrupt, 0 = level interrupt |
| status_clr | input | 1 | Clears the status flag |
| irq_n | output | 1 | Active-low interrupt |
| alarm_flag | output | 1 | Sticky alarm status |

## Verification
The bench sweeps the seconds through two full minutes with only the seconds alarm enabled. A design that needed the flag cleared between alarms would give one pulse instead of two, and one that ignored the enable bit would pulse on other seconds too. The bench holds a matching time with no tick, which catches a design that compares continuously and stretches or repeats the interrupt. It also sets every field disabled with all compare values equal to zero, which catches a design that treats 0x00 as a live compare value. Finally it raises a clear and an event in the same cycle, where a design with the wrong priority would lose the alarm.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 6;

  // enable flag of an alarm register (top bit)
  function automatic logic alarm_enabled(input logic [FIELD_W-1:0] alm);
    return alm[FIELD_W-1];
  endfunction

  // a field passes when it is disabled, or when its compare value equals the time field
  function automatic logic field_pass(input logic [FIELD_W-1:0] alm,
                                      input logic [FIELD_W-1:0] now);
    return !alarm_enabled(alm) || ({1'b0, alm[FIELD_W-2:0]} == now);
  endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import rtc_alarm_pkg::*;
(
  input  logic [FIELD_W-1:0] alm,
  input  logic [FIELD_W-1:0] now,
  output logic               pass,
  output logic               en
);
  assign en   = alarm_enabled(alm);
  assign pass = field_pass(alm, now);
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] now,
  output logic                               match,
  output logic                               any_en
);
  logic [NUM_FIELDS-1:0] pass_v;
  logic [NUM_FIELDS-1:0] en_v;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    alarm_field_cmp u_cmp (
      .alm  (alm[i]),
      .now  (now[i]),
      .pass (pass_v[i]),
      .en   (en_v[i])
    );
  end

  assign any_en = |en_v;
  assign match  = any_en && (&pass_v);
endmodule

// File: rtl/alarm_irq.sv
module alarm_irq #(
  parameter int PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic irq_mode,
  input  logic status_clr,
  output logic irq_n,
  output logic alarm_flag
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] pulse_cnt;
  logic             pulse_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt <= '0;
    end else if (evt) begin
      pulse_cnt <= LOAD;
    end else if (pulse_cnt != '0) begin
      pulse_cnt <= pulse_cnt - 1'b1;
    end
  end

  // an event outranks a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_flag <= 1'b0;
    end else if (evt) begin
      alarm_flag <= 1'b1;
    end else if (status_clr) begin
      alarm_flag <= 1'b0;
    end
  end

  assign pulse_active = (pulse_cnt != '0);
  assign irq_n = irq_mode ? !pulse_active : !alarm_flag;

  // R6
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && irq_mode) |=> (!irq_mode || !irq_n));

  // R6
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= LOAD);

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> alarm_flag);

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !status_clr) |=> alarm_flag);

  // R9
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !irq_mode) |=> (irq_mode || !irq_n));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_date,
  input  logic [7:0] now_month,
  input  logic [7:0] now_dow,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic [7:0] alm_date,
  input  logic [7:0] alm_month,
  input  logic [7:0] alm_dow,
  input  logic       irq_mode,
  input  logic       status_clr,
  output logic       irq_n,
  output logic       alarm_flag
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_v;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alm_v;
  logic match;
  logic any_en;
  logic evt;

  assign now_v = {now_dow, now_month, now_date, now_hour, now_min, now_sec};
  assign alm_v = {alm_dow, alm_month, alm_date, alm_hour, alm_min, alm_sec};

  alarm_match u_match (
    .alm    (alm_v),
    .now    (now_v),
    .match  (match),
    .any_en (any_en)
  );

  // the match counts only on the tick that follows a time update
  assign evt = sec_tick && match;

  alarm_irq #(.PULSE_CYCLES(PULSE_CYCLES)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt        (evt),
    .irq_mode   (irq_mode),
    .status_clr (status_clr),
    .irq_n      (irq_n),
    .alarm_flag (alarm_flag)
  );

  // R4
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> any_en);

  // R5
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(sec_tick));
endmodule

// File: tb/sim_rtc_alarm_irq.sv
module sim_rtc_alarm_irq;
  localparam int P = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic irq_mode = 1'b1;
  logic status_clr = 1'b0;
  logic [7:0] tf [6];
  logic [7:0] af [6];
  logic irq_n, alarm_flag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_alarm_irq #(.PULSE_CYCLES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .now_sec(tf[0]), .now_min(tf[1]), .now_hour(tf[2]),
    .now_date(tf[3]), .now_month(tf[4]), .now_dow(tf[5]),
    .alm_sec(af[0]), .alm_min(af[1]), .alm_hour(af[2]),
    .alm_date(af[3]), .alm_month(af[4]), .alm_dow(af[5]),
    .irq_mode(irq_mode), .status_clr(status_clr),
    .irq_n(irq_n), .alarm_flag(alarm_flag)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic bit exp_match();
    bit any = 0;
    bit ok = 1;
    for (int i = 0; i < 6; i++) begin
      if (af[i] >= 8'h80) begin
        any = 1;
        if ((af[i] - 8'h80) != tf[i]) ok = 0;
      end
    end
    return any && ok;
  endfunction

  task automatic check(input bit good, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic random_time();
    tf[0] = bcd($urandom_range(59));
    tf[1] = bcd($urandom_range(59));
    tf[2] = bcd($urandom_range(23));
    tf[3] = bcd($urandom_range(31, 1));
    tf[4] = bcd($urandom_range(12, 1));
    tf[5] = bcd($urandom_range(6));
  endtask

  task automatic clear_flag();
    @(negedge clk) status_clr = 1'b1;
    @(negedge clk) status_clr = 1'b0;
  endtask

  // raise a tick, then count low interrupt samples and capture the flag
  task automatic tick(output int lowcnt, output bit flag_after);
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
    flag_after = alarm_flag;
    lowcnt = 0;
    for (int k = 0; k < P + 3; k++) begin
      if (!irq_n) lowcnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    int lc;
    bit fl;
    int pulses;
    bit m;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 6; i++) begin tf[i] = 8'h00; af[i] = 8'h00; end
    repeat (3) @(negedge clk);
    check(irq_n === 1'b1, "R1", "irq_n in reset", int'(irq_n), 1);
    check(alarm_flag === 1'b0, "R1", "flag in reset", int'(alarm_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_n === 1'b1 && alarm_flag === 1'b0, "R1", "idle after reset",
          int'({irq_n, alarm_flag}), 2);

    // R4: all fields disabled, every compare value 0x00 equals the time
    irq_mode = 1'b1;
    tick(lc, fl);
    check(lc == 0, "R4", "pulse with no enables", lc, 0);
    check(fl == 0, "R4", "flag with no enables", int'(fl), 0);

    // R2/R6: seconds 0x30 enabled, time matches
    tf[0] = 8'h30; af[0] = 8'hB0;
    tick(lc, fl);
    check(lc == P, "R6", "pulse length", lc, P);
    check(fl == 1, "R2", "flag after seconds match", int'(fl), 1);

    // R3: a disabled field with a mismatched value has no effect
    clear_flag();
    af[1] = 8'h15; tf[1] = 8'h42;
    tick(lc, fl);
    check(lc == P, "R3", "disabled field ignored", lc, P);
    af[1] = 8'h95;
    tick(lc, fl);
    check(lc == 0, "R2", "enabled minute mismatch", lc, 0);
    af[1] = 8'h00;

    // R5: match present without a tick
    clear_flag();
    repeat (P + 4) @(negedge clk);
    check(irq_n === 1'b1, "R5", "irq_n without tick", int'(irq_n), 1);
    check(alarm_flag === 1'b0, "R5", "flag without tick", int'(alarm_flag), 0);

    // R9: level mode holds until clear
    irq_mode = 1'b0;
    tick(lc, fl);
    check(lc == P + 3, "R9", "level stays low", lc, P + 3);
    @(negedge clk) status_clr = 1'b1;
    @(negedge clk) status_clr = 1'b0;
    check(irq_n === 1'b1 && alarm_flag === 1'b0, "R9", "released by clear",
          int'({irq_n, alarm_flag}), 2);

    // R8: clear and event in the same cycle, event wins
    @(negedge clk) begin sec_tick = 1'b1; status_clr = 1'b1; end
    @(negedge clk) begin sec_tick = 1'b0; status_clr = 1'b0; end
    check(alarm_flag === 1'b1, "R8", "set beats clear", int'(alarm_flag), 1);
    repeat (3) @(negedge clk);
    check(alarm_flag === 1'b1, "R8", "flag held", int'(alarm_flag), 1);
    clear_flag();

    // R7: sweep two minutes, flag never cleared
    irq_mode = 1'b1;
    random_time();
    for (int i = 0; i < 6; i++) af[i] = 8'h00;
    af[0] = 8'hB0;
    pulses = 0;
    for (int s = 0; s < 120; s++) begin
      tf[0] = bcd(s % 60);
      tick(lc, fl);
      if (lc != 0) pulses++;
      check(lc == ((s % 60 == 30) ? P : 0), "R7", "pulse at second", lc,
            (s % 60 == 30) ? P : 0);
    end
    check(pulses == 2, "R7", "pulses in two minutes", pulses, 2);

    // random mix, both modes
    for (int n = 0; n < 80; n++) begin
      bit force_hit;
      clear_flag();
      irq_mode = 1'($urandom_range(1));
      random_time();
      force_hit = 1'($urandom_range(1));
      for (int i = 0; i < 6; i++) begin
        if ($urandom_range(2) == 0) af[i] = 8'($urandom_range(127));
        else af[i] = 8'h80 | (force_hit ? tf[i] : 8'($urandom_range(89)));
      end
      m = exp_match();
      tick(lc, fl);
      check(fl == m, "R2", "random flag", int'(fl), int'(m));
      if (irq_mode) check(lc == (m ? P : 0), "R6", "random pulse", lc, m ? P : 0);
      else check(lc == (m ? P + 3 : 0), "R9", "random level", lc, m ? P + 3 : 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule